// File: doc/BRIEF.md
# Timer event flag and interrupt unit

This unit holds the event status of a multifunction timer that has two capture registers, two compare registers and an up/down counter. The timer datapath is outside the unit. It reports each capture, compare match and counter wrap as a single-cycle strobe. The unit latches these strobes into an 8-bit read/write flag register. It marks an overrun when a capture-0 or compare-0 event arrives while the matching flag is still pending. It merges the pending flags with a global enable and per-source enables into one level-sensitive interrupt request.

Software clears a flag by writing 0 to it. Writing 1 to a capture flag starts a simulated capture. The unit sets the flag and sends a one-clock software-capture strobe to the capture datapath. One software-owned bit selects how the two capture flags form the capture interrupt. With the bit at 0 either flag is enough. With the bit at 1 both flags are needed.

Top module: `tmr_evt_flags`

## Requirements
- R1: After reset the flag register reads 0x00, `irq` is low and both software-capture strobes are low. The register bits, from bit 7 down to bit 0, are CP0, CP1, CM0, CM1, OUF, OCP0, OCM0, A0.
- R2: `cap0_evt` sets CP0 (bit 7) and `cap1_evt` sets CP1 (bit 6) at the next clock edge. Writing 0 to one of these bits clears it. When a hardware set and a software clear reach the same bit in the same cycle, the set wins. Without a write the bits hold their value.
- R3: `cmp0_evt`, `cmp1_evt` and `ovf_evt` set CM0 (bit 5), CM1 (bit 4) and OUF (bit 3). Writing 0 to one of these bits clears it, and writing 1 has no effect. The set wins over a clear in the same cycle.
- R4: A write with bit 7 = 1 sets CP0 and OCP0 at the next edge. In the cycle after that write, `sw_cap0_stb` is high for exactly one clock.
- R5: A write with bit 6 = 1 while `bicap_mode` = 0 sets CP1 and makes `sw_cap1_stb` high for one clock in the next cycle. While `bicap_mode` = 1, such a write leaves CP1 unchanged and gives no strobe.
- R6: OCP0 (bit 2) is set by `cap0_evt` while CP0 is already set. OCM0 (bit 1) is set by `cmp0_evt` while CM0 is already set. Writing 0 clears either bit, and writing 1 has no effect. The set wins over a clear in the same cycle.
- R7: A0 (bit 0) takes the written value on every write and is never changed by hardware.
- R8: CM0, CM1 and OUF each request an interrupt only when `glb_ie` and the matching enable (`cmp0_ie`, `cmp1_ie`, `ovf_ie`) are high. `irq` is always low while `glb_ie` is low. Overrun bits never request an interrupt.
- R9: With A0 = 0, the capture interrupt is (CP0 and `cap0_ie`) or (CP1 and `cap1_ie`), gated by `glb_ie`.
- R10: With A0 = 1, the capture interrupt needs CP0, CP1, `cap0_ie` and `cap1_ie` all high, gated by `glb_ie`.
- R11: `irq` is a combinational level taken from the registered flags and the current enables. It stays high for as long as an enabled condition remains pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Flag register write strobe |
| wr_data | input | 8 | Flag register write value |
| rd_data | output | 8 | Current flag register contents |
| cap0_evt | input | 1 | Capture into capture register 0 |
| cap1_evt | input | 1 | Capture into capture register 1 |
| cmp0_evt | input | 1 | Match on compare register 0 |
| cmp1_evt | input | 1 | Match on compare register 1 |
| ovf_evt | input | 1 | Counter overflow or underflow |
| glb_ie | input | 1 | Global timer interrupt enable |
| cap0_ie | input | 1 | Capture 0 interrupt enable |
| cap1_ie | input | 1 | Capture 1 interrupt enable |
| cmp0_ie | input | 1 | Compare 0 interrupt enable |
| cmp1_ie | input | 1 | Compare 1 interrupt enable |
| ovf_ie | input | 1 | Overflow/underflow interrupt enable |
| bicap_mode | input | 1 | Bicapture mode active, blocks software capture on register 1 |
| sw_cap0_stb | output | 1 | One-clock software capture/load strobe for capture register 0 |
| sw_cap1_stb | output | 1 | One-clock software capture strobe for capture register 1 |
| irq | output | 1 | Interrupt request level |

## Verification
The assertions assume that every strobe, enable and write input has a known value on each clock edge after reset. They also assume that `bicap_mode` is sampled in the same cycle as the write it qualifies, so a software capture on register 1 is judged by the mode in that cycle. The stimulus changes every input only at the falling edge and always drives a defined 0 or 1. It mixes sparse writes, dense event strobes and changes of enable and mode. This includes cycles where an event strobe and a clear write hit the same bit, and cycles where an event arrives on a flag that is already set.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;

    localparam int FLAG_W = 8;
    localparam int EVT_N  = 5;

    // Bit positions: software reads the register in this order.
    localparam int B_CP0  = 7;
    localparam int B_CP1  = 6;
    localparam int B_CM0  = 5;
    localparam int B_CM1  = 4;
    localparam int B_OUF  = 3;
    localparam int B_OCP0 = 2;
    localparam int B_OCM0 = 1;
    localparam int B_A0   = 0;

    typedef struct packed {
        logic cp0;
        logic cp1;
        logic cm0;
        logic cm1;
        logic ouf;
        logic ocp0;
        logic ocm0;
        logic a0;
    } flags_t;

    typedef struct packed {
        logic cp0;
        logic cp1;
        logic cm0;
        logic cm1;
        logic ouf;
    } evt_t;

    typedef struct packed {
        logic glb;
        logic cp0;
        logic cp1;
        logic cm0;
        logic cm1;
        logic ou;
    } ien_t;

endpackage

// File: rtl/tmr_evt_overrun.sv
module tmr_evt_overrun
    import tmr_evt_pkg::*;
(
    input  evt_t   evt,
    input  flags_t flags_q,
    input  logic   sw_cap0,
    output logic   set_ocp0,
    output logic   set_ocm0
);

    // A request arriving while its flag is still pending is an overrun.
    // A simulated capture always counts as one.
    always_comb begin
        set_ocp0 = sw_cap0 | (evt.cp0 & flags_q.cp0);
        set_ocm0 = evt.cm0 & flags_q.cm0;
    end

endmodule

// File: rtl/tmr_evt_flagbank.sv
module tmr_evt_flagbank
    import tmr_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_data,
    input  evt_t              evt,
    input  logic              bicap_mode,
    output flags_t            flags_q,
    output logic              sw_cap0_stb,
    output logic              sw_cap1_stb
);

    typedef struct packed {
        flags_t flags;
        logic   stb0;
        logic   stb1;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic [FLAG_W-1:0] clr_d, set_d, f_q, f_d;
    logic              sw0_d, sw1_d, set_ocp0, set_ocm0;

    assign f_q = st_q.flags;

    tmr_evt_overrun u_ovr (
        .evt      (evt),
        .flags_q  (st_q.flags),
        .sw_cap0  (sw0_d),
        .set_ocp0 (set_ocp0),
        .set_ocm0 (set_ocm0)
    );

    always_comb begin
        sw0_d = wr_en & wr_data[B_CP0];
        sw1_d = wr_en & wr_data[B_CP1] & ~bicap_mode;
        clr_d = wr_en ? ~wr_data : '0;

        set_d         = '0;
        set_d[B_CP0]  = evt.cp0 | sw0_d;
        set_d[B_CP1]  = evt.cp1 | sw1_d;
        set_d[B_CM0]  = evt.cm0;
        set_d[B_CM1]  = evt.cm1;
        set_d[B_OUF]  = evt.ouf;
        set_d[B_OCP0] = set_ocp0;
        set_d[B_OCM0] = set_ocm0;

        // Sticky bits: a clear is applied first, then the set, so the set wins.
        f_d = f_q;
        for (int i = 0; i < FLAG_W; i++) begin
            if (i != B_A0) begin
                f_d[i] = (f_q[i] & ~clr_d[i]) | set_d[i];
            end
        end
        f_d[B_A0] = wr_en ? wr_data[B_A0] : f_q[B_A0];

        st_d       = st_q;
        st_d.flags = flags_t'(f_d);
        st_d.stb0  = sw0_d;
        st_d.stb1  = sw1_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_q     = st_q.flags;
    assign sw_cap0_stb = st_q.stb0;
    assign sw_cap1_stb = st_q.stb1;

    // R2: a capture strobe always leaves CP0 set.
    p_cp0_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt.cp0 |=> flags_q.cp0);

    // R2: without a write, a set capture flag holds.
    p_cp0_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q.cp0 && !wr_en) |=> flags_q.cp0);

    // R3: a compare-0 match always leaves CM0 set.
    p_cm0_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt.cm0 |=> flags_q.cm0);

    // R4: the software strobe comes with CP0 and OCP0 both set.
    p_sw0_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sw_cap0_stb |-> (flags_q.cp0 && flags_q.ocp0));

    // R5: no register-1 software strobe follows a write made in bicapture mode.
    p_bicap_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bicap_mode) |=> !sw_cap1_stb);

    // R6: a compare-0 match on a pending CM0 leaves OCM0 set.
    p_ocm0_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.cm0 && flags_q.cm0) |=> flags_q.ocm0);

    // R7: hardware never changes A0.
    p_a0_sw_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(flags_q.a0));

endmodule

// File: rtl/tmr_evt_irq.sv
module tmr_evt_irq
    import tmr_evt_pkg::*;
(
    input  flags_t flags,
    input  ien_t   ien,
    output logic   irq
);

    logic cap_or, cap_and, cap_req, oth_req;

    always_comb begin
        cap_or  = (flags.cp0 & ien.cp0) | (flags.cp1 & ien.cp1);
        cap_and = flags.cp0 & flags.cp1 & ien.cp0 & ien.cp1;
        cap_req = flags.a0 ? cap_and : cap_or;
        oth_req = (flags.cm0 & ien.cm0) | (flags.cm1 & ien.cm1) | (flags.ouf & ien.ou);
        irq     = ien.glb & (cap_req | oth_req);
    end

endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags
    import tmr_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    input  logic        cap0_evt,
    input  logic        cap1_evt,
    input  logic        cmp0_evt,
    input  logic        cmp1_evt,
    input  logic        ovf_evt,
    input  logic        glb_ie,
    input  logic        cap0_ie,
    input  logic        cap1_ie,
    input  logic        cmp0_ie,
    input  logic        cmp1_ie,
    input  logic        ovf_ie,
    input  logic        bicap_mode,
    output logic        sw_cap0_stb,
    output logic        sw_cap1_stb,
    output logic        irq
);

    evt_t   evt;
    ien_t   ien;
    flags_t flags_q;

    assign evt = '{cp0: cap0_evt, cp1: cap1_evt, cm0: cmp0_evt, cm1: cmp1_evt, ouf: ovf_evt};
    assign ien = '{glb: glb_ie, cp0: cap0_ie, cp1: cap1_ie, cm0: cmp0_ie, cm1: cmp1_ie, ou: ovf_ie};

    tmr_evt_flagbank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .evt         (evt),
        .bicap_mode  (bicap_mode),
        .flags_q     (flags_q),
        .sw_cap0_stb (sw_cap0_stb),
        .sw_cap1_stb (sw_cap1_stb)
    );

    tmr_evt_irq u_irq (
        .flags (flags_q),
        .ien   (ien),
        .irq   (irq)
    );

    assign rd_data = flags_q;

    // R8: the global enable gates every source.
    p_glb_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_ie |-> !irq);

    // R10: in AND mode, with no compare or wrap request pending, irq needs both captures.
    p_and_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && rd_data[B_A0] && !(rd_data[B_CM0] || rd_data[B_CM1] || rd_data[B_OUF]))
        |-> (rd_data[B_CP0] && rd_data[B_CP1] && cap0_ie && cap1_ie));

    // R11: with enables unchanged and no write, a raised request stays raised.
    p_level_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_en) |=>
        (irq || !$stable({glb_ie, cap0_ie, cap1_ie, cmp0_ie, cmp1_ie, ovf_ie})));

endmodule

// File: tb/tmr_evt_flags_test.sv
`timescale 1ns/1ps
module tmr_evt_flags_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [4:0] ev = '0;      // cap0, cap1, cmp0, cmp1, ovf
    logic [5:0] ie = '0;      // glb, cap0, cap1, cmp0, cmp1, ovf
    logic       bicap = 1'b0;
    logic [7:0] rd_data;
    logic       sw_cap0_stb, sw_cap1_stb, irq;

    int n_chk = 0;
    int n_fail = 0;

    // Reference state
    bit m_cp0, m_cp1, m_cm0, m_cm1, m_ouf, m_ocp0, m_ocm0, m_a0;
    bit m_s0, m_s1;

    always #4 clk = ~clk;

    tmr_evt_flags uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .cap0_evt(ev[4]), .cap1_evt(ev[3]), .cmp0_evt(ev[2]), .cmp1_evt(ev[1]), .ovf_evt(ev[0]),
        .glb_ie(ie[5]), .cap0_ie(ie[4]), .cap1_ie(ie[3]), .cmp0_ie(ie[2]), .cmp1_ie(ie[1]),
        .ovf_ie(ie[0]), .bicap_mode(bicap),
        .sw_cap0_stb(sw_cap0_stb), .sw_cap1_stb(sw_cap1_stb), .irq(irq)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_irq();
        bit cap, oth;
        if (m_a0) cap = m_cp0 && m_cp1 && ie[4] && ie[3];
        else      cap = (m_cp0 && ie[4]) || (m_cp1 && ie[3]);
        oth = (m_cm0 && ie[2]) || (m_cm1 && ie[1]) || (m_ouf && ie[0]);
        return ie[5] && (cap || oth);
    endfunction

    task automatic check_regs();
        chk("R2 capture flags", {6'b0, rd_data[7:6]}, {6'b0, m_cp0, m_cp1});
        chk("R3 compare/wrap flags", {5'b0, rd_data[5:3]}, {5'b0, m_cm0, m_cm1, m_ouf});
        chk("R6 overrun flags", {6'b0, rd_data[2:1]}, {6'b0, m_ocp0, m_ocm0});
        chk("R7 A0", {7'b0, rd_data[0]}, {7'b0, m_a0});
        chk("R4 sw capture 0 strobe", {7'b0, sw_cap0_stb}, {7'b0, m_s0});
        chk("R5 sw capture 1 strobe", {7'b0, sw_cap1_stb}, {7'b0, m_s1});
    endtask

    // One cycle: drive at the falling edge, check irq, advance model, check registers.
    task automatic step(bit w, logic [7:0] d, logic [4:0] e, logic [5:0] en, bit bc);
        bit sw0, sw1, o_cp0, o_cm0;
        wr_en = w; wr_data = d; ev = e; ie = en; bicap = bc;
        #1;
        if (!en[5])     chk("R8 irq gated off", {7'b0, irq}, {7'b0, exp_irq()});
        else if (m_a0)  chk("R10 irq AND mode", {7'b0, irq}, {7'b0, exp_irq()});
        else            chk("R9 irq OR mode", {7'b0, irq}, {7'b0, exp_irq()});
        sw0 = w && d[7];
        sw1 = w && d[6] && !bc;
        o_cp0 = m_cp0;
        o_cm0 = m_cm0;
        if (w && !d[7]) m_cp0 = 0;
        if (e[4] || sw0) m_cp0 = 1;
        if (w && !d[6]) m_cp1 = 0;
        if (e[3] || sw1) m_cp1 = 1;
        if (w && !d[5]) m_cm0 = 0;
        if (e[2]) m_cm0 = 1;
        if (w && !d[4]) m_cm1 = 0;
        if (e[1]) m_cm1 = 1;
        if (w && !d[3]) m_ouf = 0;
        if (e[0]) m_ouf = 1;
        if (w && !d[2]) m_ocp0 = 0;
        if (sw0 || (e[4] && o_cp0)) m_ocp0 = 1;
        if (w && !d[1]) m_ocm0 = 0;
        if (e[2] && o_cm0) m_ocm0 = 1;
        if (w) m_a0 = d[0];
        m_s0 = sw0;
        m_s1 = sw1;
        @(negedge clk);
        check_regs();
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset flags", rd_data, 8'h00);
        chk("R1 reset irq", {7'b0, irq}, 8'h00);
        chk("R1 reset strobes", {6'b0, sw_cap0_stb, sw_cap1_stb}, 8'h00);

        // R3: writing 1 to hardware-only flags does nothing
        step(1, 8'h3A, 5'b0, 6'b0, 0);
        // R2: set wins over clear in the same cycle
        step(1, 8'h00, 5'b10000, 6'b0, 0);
        // R6: second capture while CP0 pending
        step(0, 8'h00, 5'b10000, 6'b0, 0);
        // R5: software capture on register 1 blocked in bicapture mode
        step(1, 8'h40, 5'b0, 6'b0, 1);
        step(1, 8'h40, 5'b0, 6'b0, 0);
        // R11: compare 0 with enables, level held over idle cycles
        step(1, 8'h00, 5'b00100, 6'b100100, 0);
        for (int i = 0; i < 4; i++) begin
            step(0, 8'h00, 5'b0, 6'b100100, 0);
            chk("R11 irq held", {7'b0, irq}, 8'h01);
        end
        // R10: AND mode with one capture pending
        step(1, 8'h81, 5'b0, 6'b111000, 0);
        step(0, 8'h00, 5'b01000, 6'b111000, 0);
        step(1, 8'h00, 5'b0, 6'b111000, 0);

        for (int i = 0; i < 4000; i++) begin
            bit w;
            logic [4:0] e;
            logic [5:0] en;
            w = ($urandom % 5) == 0;
            e = 5'($urandom) & 5'($urandom);
            en = (i % 16 == 0) ? 6'($urandom) : ie;
            step(w, 8'($urandom), e, en, (i % 200) > 120);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule